// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is a write-back, direct-mapped cache controller. It keeps copies coherent across several caches that sit on one snooped bus. Invalidation is not used. When a cache writes data that other caches may also hold, it broadcasts only the written word, and every cache that holds the block patches its own copy. A resident line is always valid. It is in one of four states:

- exclusive-clean: the only copy, and it matches memory.
- shared-clean: other copies may exist, and this cache does not own the block.
- shared-modified: copies may exist, the data is dirty, and this cache owns it.
- modified: the only copy, and it is dirty.

Lines that are not present count as invalid.

The controller serves a processor port, one request at a time. It masters the bus through a request/grant pair and issues three kinds of transaction: line reads, single-word updates and dirty-line writebacks. It also watches the transactions of other masters on a snoop port. For a snooped read or update that hits a resident line, it drives its contribution to the wired-OR shared signal. A snooped read of a dirty line makes it flush the whole line. Memory is never written by an update; the shared-modified owner keeps the dirty data until it replaces the line.

Top module: `wu_ctrl`

## Requirements
- R1: After reset no line is resident. The first access to any address misses. `bus_req` and `cpu_ready` are low, and a snooped read or update reports `snp_shared` low.
- R2: A read miss issues a line read (`bus_cmd` 2'b01). The read address is the request address with the word offset cleared, where the address splits as {tag, index, offset} from the top bit down. The line fills as shared-clean if `bus_shared_in` is high in the grant cycle and as exclusive-clean if it is not. The requested word is returned.
- R3: A write miss issues a line read. If the shared signal is high during that read, the controller then issues an update (`bus_cmd` 2'b10) and the line ends shared-modified or modified, chosen by the shared signal during the update. If the shared signal is low during the read, the word is written locally and the line ends modified with no update.
- R4: A write hit on a shared-clean or shared-modified line issues an update that carries the full word address on `bus_addr` and the word on `bus_word`. The line ends shared-modified if `bus_shared_in` is high in its grant cycle and modified if it is not.
- R5: A write hit on an exclusive-clean or modified line, and any read hit, complete with no bus transaction. The exclusive-clean line becomes modified.
- R6: A snooped update (`snp_cmd` 2'b10) that hits a resident line overwrites the addressed word. A shared-modified line that receives one becomes shared-clean.
- R7: A snooped read (`snp_cmd` 2'b01) that hits a modified or shared-modified line raises `snp_flush` with the line on `snp_line` (word w at bits [w*DATA_W +: DATA_W]), and the line becomes shared-modified. An exclusive-clean line becomes shared-clean. A shared-clean line does not flush.
- R8: `snp_shared` is high exactly when a snooped read or update hits a resident line. It is low for a snooped writeback (2'b11) and for misses.
- R9: During a write hit, the local copy keeps its old word until the update is granted. A snooped read made while the update waits flushes the old data.
- R10: A miss whose victim line is modified or shared-modified first writes that line back (`bus_cmd` 2'b11, victim address, line on `bus_wdata`) and then reads. A clean victim is dropped without bus traffic.
- R11: A bus request holds its command and address steady until it is granted. `cpu_ready` is a one-cycle pulse that comes with `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; the transaction completes in the granted cycle |
| bus_cmd | output | 2 | 01 read, 10 update, 11 writeback |
| bus_addr | output | ADDR_W | Line address (read, writeback) or word address (update) |
| bus_wdata | output | WORDS*DATA_W | Writeback line |
| bus_word | output | DATA_W | Update word |
| bus_rdata | input | WORDS*DATA_W | Fill line, valid in the grant cycle |
| bus_shared_in | input | 1 | Wired-OR shared signal, sampled in the grant cycle |
| snp_valid | input | 1 | Another master's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_word | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache's contribution to the shared signal |
| snp_flush | output | 1 | This cache supplies the line |
| snp_line | output | WORDS*DATA_W | Line supplied on a flush |

## Verification
The bench uses the defaults: 8-bit word addresses, 16-bit words, four lines of two words. It draws addresses from only four tags, so random traffic often hits, often evicts, and often collides with snoops on lines that are present. Two words per line let a snooped update touch one word while a read checks the other. Forcing the shared signal high or low reaches every fill and write ending directly, and random shared values mix them during the random phase.

// File: rtl/wu_pkg.sv
`timescale 1ns/1ps
package wu_pkg;

  typedef enum logic [1:0] {
    LS_EXCL  = 2'd0,
    LS_SHCLN = 2'd1,
    LS_SHMOD = 2'd2,
    LS_MOD   = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_READ   = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_WBACK = 2'd1,
    F_FILL  = 2'd2,
    F_UPD   = 2'd3
  } fsm_e;

  // Dirty data that this cache must supply or write back
  function automatic logic owns_dirty(line_st_e s);
    return (s == LS_SHMOD) || (s == LS_MOD);
  endfunction

  // State of a resident line after another master's transaction
  function automatic line_st_e snoop_next(line_st_e s, bus_cmd_e c);
    case (c)
      BC_READ:   return (s == LS_EXCL) ? LS_SHCLN : ((s == LS_MOD) ? LS_SHMOD : s);
      BC_UPDATE: return (s == LS_SHMOD) ? LS_SHCLN : s;
      default:   return s;
    endcase
  endfunction

  function automatic line_st_e fill_state(logic shared);
    return shared ? LS_SHCLN : LS_EXCL;
  endfunction

  function automatic line_st_e write_state(logic shared);
    return shared ? LS_SHMOD : LS_MOD;
  endfunction

endpackage

// File: rtl/wu_lookup.sv
`timescale 1ns/1ps
module wu_lookup #(
  parameter int LINES = 4,
  parameter int TAG_W = 5,
  parameter int IDX_W = 2
) (
  input  logic [LINES-1:0]       vld,
  input  logic [LINES*TAG_W-1:0] tag_flat,
  input  logic [IDX_W-1:0]       idx,
  input  logic [TAG_W-1:0]       tag,
  output logic                   hit
);
  assign hit = vld[idx] && (tag_flat[idx*TAG_W +: TAG_W] == tag);
endmodule

// File: rtl/wu_word_merge.sv
`timescale 1ns/1ps
module wu_word_merge #(
  parameter int WORDS  = 2,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 1
) (
  input  logic [WORDS*DATA_W-1:0] line_in,
  input  logic [OFF_W-1:0]        off,
  input  logic [DATA_W-1:0]       word_in,
  output logic [WORDS*DATA_W-1:0] line_out
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign line_out[w*DATA_W +: DATA_W] =
      (off == OFF_W'(w)) ? word_in : line_in[w*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/wu_ctrl.sv
`timescale 1ns/1ps
module wu_ctrl
  import wu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int WORDS  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [WORDS*DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0]       bus_word,
  input  logic [WORDS*DATA_W-1:0] bus_rdata,
  input  logic                    bus_shared_in,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  input  logic [DATA_W-1:0]       snp_word,
  output logic                    snp_shared,
  output logic                    snp_flush,
  output logic [WORDS*DATA_W-1:0] snp_line
);
  localparam int OFF_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = WORDS * DATA_W;

  // Line storage
  logic [LINES-1:0]       vld_q;
  logic [TAG_W-1:0]       tag_q [LINES];
  line_st_e               st_q  [LINES];
  logic [LINE_W-1:0]      dat_q [LINES];
  logic [LINES*TAG_W-1:0] tag_flat;

  for (genvar g = 0; g < LINES; g++) begin : g_tagflat
    assign tag_flat[g*TAG_W +: TAG_W] = tag_q[g];
  end

  // Held processor request
  fsm_e              fsm_q, fsm_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic [ADDR_W-1:0] a_addr;
  logic              a_we;
  logic [DATA_W-1:0] a_wdata;
  assign a_addr  = (fsm_q == F_IDLE) ? cpu_addr  : addr_q;
  assign a_we    = (fsm_q == F_IDLE) ? cpu_we    : we_q;
  assign a_wdata = (fsm_q == F_IDLE) ? cpu_wdata : wdata_q;

  logic [OFF_W-1:0] a_off, s_off;
  logic [IDX_W-1:0] a_idx, s_idx;
  logic [TAG_W-1:0] a_tag, s_tag;
  assign a_off = a_addr[OFF_W-1:0];
  assign a_idx = a_addr[OFF_W +: IDX_W];
  assign a_tag = a_addr[ADDR_W-1 -: TAG_W];
  assign s_off = snp_addr[OFF_W-1:0];
  assign s_idx = snp_addr[OFF_W +: IDX_W];
  assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];

  logic cpu_hit, snp_hit;
  wu_lookup #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cpu_look (
    .vld(vld_q), .tag_flat(tag_flat), .idx(a_idx), .tag(a_tag), .hit(cpu_hit));
  wu_lookup #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_snp_look (
    .vld(vld_q), .tag_flat(tag_flat), .idx(s_idx), .tag(s_tag), .hit(snp_hit));

  // Word merges: processor write (on the fill line when filling) and snooped update
  logic [LINE_W-1:0] base_line, wr_line, snp_upd_line;
  logic [DATA_W-1:0] rd_word;
  assign base_line = (fsm_q == F_FILL) ? bus_rdata : dat_q[a_idx];
  assign rd_word   = base_line[a_off*DATA_W +: DATA_W];

  wu_word_merge #(.WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_cpu_merge (
    .line_in(base_line), .off(a_off), .word_in(a_wdata), .line_out(wr_line));
  wu_word_merge #(.WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_snp_merge (
    .line_in(dat_q[s_idx]), .off(s_off), .word_in(snp_word), .line_out(snp_upd_line));

  // Snoop side
  bus_cmd_e s_cmd;
  logic     snp_touch;
  assign s_cmd      = bus_cmd_e'(snp_cmd);
  assign snp_touch  = snp_valid && snp_hit && (s_cmd == BC_READ || s_cmd == BC_UPDATE);
  assign snp_shared = snp_touch;
  assign snp_flush  = snp_touch && (s_cmd == BC_READ) && owns_dirty(st_q[s_idx]);
  assign snp_line   = dat_q[s_idx];

  // Named internal events
  line_st_e cur_st;
  logic accept, ev_exc_write_hit, ev_upd_done, ev_wb_done;
  assign cur_st           = st_q[a_idx];
  assign accept           = (fsm_q == F_IDLE) && cpu_req && !snp_valid && !cpu_ready;
  assign ev_exc_write_hit = accept && cpu_hit && cpu_we &&
                            (cur_st == LS_EXCL || cur_st == LS_MOD);
  assign ev_upd_done      = (fsm_q == F_UPD)   && bus_gnt;
  assign ev_wb_done       = (fsm_q == F_WBACK) && bus_gnt;

  // Bus master outputs
  always_comb begin
    bus_cmd  = BC_NONE;
    bus_addr = '0;
    case (fsm_q)
      F_WBACK: begin bus_cmd = BC_WBACK;  bus_addr = {tag_q[a_idx], a_idx, {OFF_W{1'b0}}}; end
      F_FILL:  begin bus_cmd = BC_READ;   bus_addr = {a_tag, a_idx, {OFF_W{1'b0}}}; end
      F_UPD:   begin bus_cmd = BC_UPDATE; bus_addr = a_addr; end
      default: ;
    endcase
  end
  assign bus_req   = (fsm_q != F_IDLE);
  assign bus_wdata = dat_q[a_idx];
  assign bus_word  = a_wdata;

  // Next-state decisions for the processor side
  logic              rdy_d, wr_dat, wr_st, set_vld, clr_vld;
  logic [DATA_W-1:0] rdata_d;
  logic [LINE_W-1:0] dat_v;
  line_st_e          st_v;

  always_comb begin
    fsm_d   = fsm_q;
    rdy_d   = 1'b0;
    rdata_d = cpu_rdata;
    wr_dat  = 1'b0;
    wr_st   = 1'b0;
    set_vld = 1'b0;
    clr_vld = 1'b0;
    dat_v   = wr_line;
    st_v    = cur_st;
    case (fsm_q)
      F_IDLE: if (accept) begin
        if (cpu_hit) begin
          if (!a_we) begin
            rdy_d = 1'b1; rdata_d = rd_word;
          end else if (cur_st == LS_EXCL || cur_st == LS_MOD) begin
            wr_dat = 1'b1; wr_st = 1'b1; st_v = LS_MOD; rdy_d = 1'b1;
          end else begin
            fsm_d = F_UPD;
          end
        end else begin
          fsm_d = (vld_q[a_idx] && owns_dirty(cur_st)) ? F_WBACK : F_FILL;
        end
      end
      F_WBACK: if (bus_gnt) begin
        clr_vld = 1'b1; fsm_d = F_FILL;
      end
      F_FILL: if (bus_gnt) begin
        set_vld = 1'b1; wr_dat = 1'b1; wr_st = 1'b1;
        if (!a_we) begin
          dat_v = bus_rdata; st_v = fill_state(bus_shared_in);
          rdy_d = 1'b1; rdata_d = rd_word; fsm_d = F_IDLE;
        end else if (bus_shared_in) begin
          dat_v = bus_rdata; st_v = LS_SHCLN; fsm_d = F_UPD;
        end else begin
          st_v = LS_MOD; rdy_d = 1'b1; fsm_d = F_IDLE;
        end
      end
      F_UPD: if (bus_gnt) begin
        wr_dat = 1'b1; wr_st = 1'b1; st_v = write_state(bus_shared_in);
        rdy_d = 1'b1; fsm_d = F_IDLE;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      vld_q     <= '0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      fsm_q     <= fsm_d;
      cpu_ready <= rdy_d;
      cpu_rdata <= rdata_d;
      if (accept) begin
        we_q <= cpu_we; addr_q <= cpu_addr; wdata_q <= cpu_wdata;
      end
      if (clr_vld) vld_q[a_idx] <= 1'b0;
      if (set_vld) vld_q[a_idx] <= 1'b1;
    end
  end

  // Line arrays; snooped and own writes never share a cycle (no snoop in a grant cycle)
  always_ff @(posedge clk) begin
    if (snp_touch) begin
      st_q[s_idx] <= snoop_next(st_q[s_idx], s_cmd);
      if (s_cmd == BC_UPDATE) dat_q[s_idx] <= snp_upd_line;
    end
    if (wr_dat)  dat_q[a_idx] <= dat_v;
    if (wr_st)   st_q[a_idx]  <= st_v;
    if (set_vld) tag_q[a_idx] <= a_tag;
  end

endmodule

// File: rtl/wu_ctrl_chk.sv
`timescale 1ns/1ps
module wu_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_flush,
  input logic              snp_shared,
  input logic              ev_exc_write_hit,
  input logic              ev_upd_done,
  input logic              ev_wb_done
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_cmd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_cmd != 2'd0);

  p_exc_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exc_write_hit |=> !bus_req && cpu_ready);

  p_upd_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upd_done |=> cpu_ready && !bus_req);

  p_flush_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_shared);

  p_wb_then_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> bus_req && bus_cmd == 2'd1);
endmodule

bind wu_ctrl wu_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .snp_flush(snp_flush), .snp_shared(snp_shared),
  .ev_exc_write_hit(ev_exc_write_hit), .ev_upd_done(ev_upd_done),
  .ev_wb_done(ev_wb_done));

// File: tb/test_wu_ctrl.sv
`timescale 1ns/1ps
module test_wu_ctrl;
  localparam int EC = 0, SC = 1, SM = 2, MM = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [7:0]  cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        bus_req, bus_gnt = 0, bus_shared_in = 0;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata = 0, snp_line;
  logic [15:0] bus_word;
  logic        snp_valid = 0;
  logic [1:0]  snp_cmd = 0;
  logic [7:0]  snp_addr = 0;
  logic [15:0] snp_word = 0;
  logic        snp_shared, snp_flush;

  wu_ctrl i_wu_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_word(bus_word), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_word(snp_word), .snp_shared(snp_shared), .snp_flush(snp_flush),
    .snp_line(snp_line));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, sh_force = -1;
  bit         finished = 0;
  bit         m_vld [4];
  logic [4:0] m_tag [4];
  int         m_st  [4];
  logic [15:0] m_dat [4][2];
  logic [15:0] mem [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit dirty(int s);
    return s == SM || s == MM;
  endfunction

  function automatic logic [31:0] mem_line(logic [7:0] a);
    logic [7:0] b = {a[7:1], 1'b0};
    return {mem[b + 8'd1], mem[b]};
  endfunction

  function automatic bit pick_sh();
    return (sh_force < 0) ? 1'($urandom % 2) : 1'(sh_force);
  endfunction

  function automatic logic [7:0] rnd_addr();
    logic [1:0] t = 2'($urandom % 4);
    logic [2:0] io = 3'($urandom % 8);
    return {3'b000, t, io};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic [15:0] w);
    logic [1:0] ix = a[2:1];
    bit hit = m_vld[ix] && m_tag[ix] == a[7:3];
    bit e_sh = hit && (c == 2'd1 || c == 2'd2);
    bit e_fl = e_sh && c == 2'd1 && dirty(m_st[ix]);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_word = w;
    #1;
    chk(snp_shared == e_sh, "R8", "snp_shared", 32'(snp_shared), 32'(e_sh));
    chk(snp_flush == e_fl, "R7", "snp_flush", 32'(snp_flush), 32'(e_fl));
    if (e_fl)
      chk(snp_line == {m_dat[ix][1], m_dat[ix][0]}, "R7", "flushed line",
          snp_line, {m_dat[ix][1], m_dat[ix][0]});
    @(posedge clk); #1 snp_valid = 0;
    if (c == 2'd2) mem[a] = w;
    if (hit && c == 2'd1) begin
      if (m_st[ix] == EC) m_st[ix] = SC;
      else if (m_st[ix] == MM) m_st[ix] = SM;
    end
    if (hit && c == 2'd2) begin
      m_dat[ix][a[0]] = w;
      if (m_st[ix] == SM) m_st[ix] = SC;
    end
  endtask

  task automatic do_op(input bit we, input logic [7:0] a, input logic [15:0] d, input bit inject);
    logic [1:0] ix = a[2:1];
    logic [4:0] tg = a[7:3];
    bit hit = m_vld[ix] && m_tag[ix] == tg;
    int phase;   // 0 done, 1 writeback, 2 read, 3 update
    bit done = 0, injected = 0, sh;
    int guard = 0;
    logic [7:0] e_addr;
    if (hit) begin
      if (!we) phase = 0;
      else if (m_st[ix] == EC || m_st[ix] == MM) begin
        phase = 0; m_dat[ix][a[0]] = d; m_st[ix] = MM;
      end else phase = 3;
    end else phase = (m_vld[ix] && dirty(m_st[ix])) ? 1 : 2;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    while (!done) begin
      @(negedge clk);
      guard++;
      if (guard > 60) begin
        chk(0, "R11", "operation hung", 32'(guard), 32'd60);
        cpu_req = 0; done = 1;
      end else if (cpu_ready) begin
        cpu_req = 0; done = 1;
        chk(phase == 0, "R5", "completed before expected bus traffic", 32'(phase), 32'd0);
        if (!we) chk(cpu_rdata == m_dat[ix][a[0]], "R2", "read data", cpu_rdata, m_dat[ix][a[0]]);
      end else if (bus_req) begin
        if (phase == 0) begin
          chk(0, "R5", "unexpected bus command", 32'(bus_cmd), 32'd0);
          cpu_req = 0; done = 1;
        end else begin
          chk(bus_cmd == 2'(phase == 1 ? 3 : (phase == 2 ? 1 : 2)),
              phase == 1 ? "R10" : (phase == 2 ? "R3" : "R4"), "bus command",
              32'(bus_cmd), 32'(phase == 1 ? 3 : (phase == 2 ? 1 : 2)));
          if (phase == 3 && inject && !injected) begin
            injected = 1;
            snoop(2'd1, a, 16'h0);   // R9: old word must still be flushed
            continue;
          end
          if ($urandom % 3 == 0) continue;  // hold the grant back (R11)
          sh = pick_sh();
          e_addr = (phase == 1) ? {m_tag[ix], ix, 1'b0} : (phase == 2) ? {tg, ix, 1'b0} : a;
          chk(bus_addr == e_addr, phase == 1 ? "R10" : "R2", "bus address", 32'(bus_addr), 32'(e_addr));
          if (phase == 1)
            chk(bus_wdata == {m_dat[ix][1], m_dat[ix][0]}, "R10", "writeback line",
                bus_wdata, {m_dat[ix][1], m_dat[ix][0]});
          if (phase == 3) chk(bus_word == d, "R4", "update word", 32'(bus_word), 32'(d));
          bus_rdata = mem_line(a); bus_shared_in = sh; bus_gnt = 1;
          @(posedge clk); #1 bus_gnt = 0; bus_shared_in = 0;
          case (phase)
            1: begin
              mem[{m_tag[ix], ix, 1'b0}] = m_dat[ix][0];
              mem[{m_tag[ix], ix, 1'b1}] = m_dat[ix][1];
              m_vld[ix] = 0; phase = 2;
            end
            2: begin
              m_vld[ix] = 1; m_tag[ix] = tg;
              m_dat[ix][0] = mem[{tg, ix, 1'b0}]; m_dat[ix][1] = mem[{tg, ix, 1'b1}];
              if (!we) begin m_st[ix] = sh ? SC : EC; phase = 0; end
              else if (sh) begin m_st[ix] = SC; phase = 3; end
              else begin m_dat[ix][a[0]] = d; m_st[ix] = MM; phase = 0; end
            end
            default: begin m_dat[ix][a[0]] = d; m_st[ix] = sh ? SM : MM; phase = 0; end
          endcase
        end
      end
    end
    @(negedge clk);
    chk(cpu_ready == 0, "R11", "ready pulse width", 32'(cpu_ready), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5a3c;
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_st[i] = EC; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_req == 0, "R1", "bus_req after reset", 32'(bus_req), 32'd0);
    chk(cpu_ready == 0, "R1", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
    snoop(2'd1, 8'h00, 16'h0);   // R1: nothing resident
    snoop(2'd2, 8'h13, 16'h1234);

    // R2 exclusive fill, R5 silent write, R7 flush from modified
    sh_force = 0;
    do_op(0, 8'h02, 16'h0, 0);
    do_op(1, 8'h02, 16'hbeef, 0);
    do_op(0, 8'h02, 16'h0, 0);
    snoop(2'd1, 8'h02, 16'h0);
    // R2 shared fill, R4 update, R6 snooped update, R7 clean no flush
    sh_force = 1;
    do_op(0, 8'h04, 16'h0, 0);
    do_op(1, 8'h05, 16'h7777, 0);
    snoop(2'd2, 8'h04, 16'h4321);
    do_op(0, 8'h04, 16'h0, 0);
    snoop(2'd1, 8'h04, 16'h0);
    snoop(2'd3, 8'h04, 16'h0);   // R8: writeback not answered
    // R3 write miss with shared, R9 pending update keeps old word
    do_op(1, 8'h06, 16'haaaa, 0);
    do_op(1, 8'h07, 16'h5555, 1);
    do_op(0, 8'h07, 16'h0, 0);
    // R10 dirty victim then clean victim
    do_op(0, 8'h0e, 16'h0, 0);
    do_op(0, 8'h06, 16'h0, 0);
    // R3 write miss without shared
    sh_force = 0;
    do_op(1, 8'h18, 16'h0f0f, 0);

    sh_force = -1;
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 10 < 6)
        do_op(1'($urandom % 2), rnd_addr(), 16'($urandom), 1'($urandom % 8 == 0));
      else
        snoop(2'(1 + $urandom % 3), rnd_addr(), 16'($urandom));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule